// File: doc/BRIEF.md
# Serial Receive Queue with Status Mode

This block is the receive side of one serial channel, placed after character deserialisation. Each received character comes with break, framing error, receiver overrun and parity error flags. The block stores the character and its flags together in a deep queue held in block RAM. The host drains the queue through a 16-bit data port.

The data port has two formats, chosen by a status-mode input. In status mode each read returns one character with its error flags beside it. Otherwise each read returns two consecutive characters.

The block also keeps a channel status word. Its low byte mirrors live line and transmitter conditions. Its high byte holds sticky error, compare-match and overflow flags, and a status-word read clears those flags.

A programmable fill threshold drives a trigger flag, and an interrupt request that can be gated on and off. A flush input empties the queue.

Top module: `serial_rx_queue`

## Requirements
- R1: The queue holds at most 1023 characters, and `rx_count` reports how many are stored. A character that arrives while the queue is full is dropped and sets the overflow flag, bit 13 of `stat_word`. The stored characters are unchanged and the dropped character's error flags are not recorded.
- R2: With `cfg_stat_mode` high, a read removes one character. It returns the data in bits 7:0 and that character's flags in bits 11:8: break at bit 11, framing at bit 10, overrun at bit 9 and parity at bit 8. Bits 15:12 read zero.
- R3: With `cfg_stat_mode` low, a read removes two characters and returns the older one in bits 7:0 and the newer one in bits 15:8. If only one character is stored, bits 15:8 read 0x00. A read of an empty queue returns 0x0000 and leaves the count at zero.
- R4: The low byte of `stat_word` holds live flags: CTS at bit 5, DSR at bit 4, CD at bit 3, transmit queue empty at bit 2, transmit shifter empty at bit 1, and receive data available (queue not empty) at bit 0.
- R5: Bit 15 of `stat_word` reflects status mode. Bits 10, 9 and 8 are sticky flags, set when a stored character has break, framing error or parity error respectively. Bit 14 reads zero.
- R6: A pulse on `stat_rd` clears bits 13:8 of `stat_word` at the next clock edge. A flag event in the same cycle as the pulse still leaves its flag set.
- R7: Bit 11 is set when a stored character equals `cfg_cmp1` while `cfg_cmp1_en` is high. Bit 12 is set in the same way from `cfg_cmp2` and `cfg_cmp2_en`.
- R8: The trigger code `cfg_trig` selects the fill level: 00 never triggers, 01 triggers at 1 or more characters, 10 at 512 or more, and 11 at 896 or more. `trig_flag` follows the count one cycle later.
- R9: `trig_flag` is raised whether or not the interrupt is enabled. `rx_irq` is high only when `trig_flag` is high and `cfg_rx_int_en` is high.
- R10: `flush` empties the queue and zeroes the count. A character presented in the same cycle is discarded and does not set overflow. The sticky flags are kept.
- R11: After reset the count is zero, `stat_word` holds only the live input bits, and `trig_flag`, `rx_irq` and `rd_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_char | input | 8 | Received character |
| rx_brk | input | 1 | Character received as break |
| rx_frm | input | 1 | Character had a framing error |
| rx_ovr | input | 1 | Receiver overrun flagged on character |
| rx_par | input | 1 | Character had a parity error |
| cts_in | input | 1 | CTS line level |
| dsr_in | input | 1 | DSR line level |
| cd_in | input | 1 | CD line level |
| tx_fifo_empty | input | 1 | Transmit queue empty |
| tx_shift_empty | input | 1 | Transmit shifter empty |
| cfg_stat_mode | input | 1 | Status-mode read format select |
| cfg_trig | input | 2 | Trigger level code |
| cfg_rx_int_en | input | 1 | Receive interrupt enable |
| cfg_cmp1_en | input | 1 | Compare value 1 enable |
| cfg_cmp1 | input | 8 | Compare value 1 |
| cfg_cmp2_en | input | 1 | Compare value 2 enable |
| cfg_cmp2 | input | 8 | Compare value 2 |
| flush | input | 1 | Empty the queue |
| rd_req | input | 1 | Data port read request pulse |
| rd_ack | output | 1 | Read result valid pulse |
| rd_data | output | 16 | Read result |
| stat_rd | input | 1 | Status word read pulse, clears sticky flags |
| stat_word | output | 16 | Channel status word |
| rx_count | output | 10 | Characters stored |
| trig_flag | output | 1 | Fill threshold reached |
| rx_irq | output | 1 | Gated receive interrupt request |

## Verification
The hardest case to reach is the full-queue boundary. Showing that the dropped character leaves no trace means filling all 1023 entries, offering one more character with a break flag set, and then draining every entry in status mode. Each drained entry is compared against the index pattern used to fill the queue, and the break sticky flag must still be clear. The trigger thresholds are passed on the same fill: the count stops one short of each threshold before the level code is switched.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_ONE  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_7_8  = 2'b11
  } trig_sel_e;

  // One stored character: flags above data, laid out as the status-mode read
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       ovr;
    logic       par;
    logic [7:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_FIRST,
    RD_SECOND
  } rd_state_e;

endpackage

// File: rtl/rxq_ram.sv
module rxq_ram #(
  parameter int AW = 10,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_req,
  input  logic          pop,
  input  logic [1:0]    cfg_trig,
  input  logic          int_en,
  output logic          accept,
  output logic          ovf_evt,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] count,
  output logic          trig_flag,
  output logic          irq
);
  localparam logic [AW-1:0] CAP      = {AW{1'b1}};
  localparam logic [AW-1:0] HALF_LVL = AW'(2 ** (AW - 1));
  localparam logic [AW-1:0] HI_LVL   = AW'(7 * (2 ** (AW - 3)));

  logic full;
  logic lvl_hit;

  assign full    = (count == CAP);
  assign accept  = wr_req & ~flush & ~full;
  assign ovf_evt = wr_req & ~flush & full;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (accept) wptr <= wptr + 1'b1;
      if (pop)    rptr <= rptr + 1'b1;
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    case (trig_sel_e'(cfg_trig))
      TRIG_OFF:  lvl_hit = 1'b0;
      TRIG_ONE:  lvl_hit = (count != '0);
      TRIG_HALF: lvl_hit = (count >= HALF_LVL);
      default:   lvl_hit = (count >= HI_LVL);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      trig_flag <= lvl_hit;
      irq       <= trig_flag & int_en;
    end
  end
endmodule

// File: rtl/rxq_rdport.sv
module rxq_rdport
  import rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        rd_req,
  input  logic        stat_mode,
  input  logic        not_empty,
  input  rx_entry_t   ram_q,
  output logic        pop,
  output logic        rd_ack,
  output logic [15:0] rd_data
);
  rd_state_e  state;
  logic       mode_q;
  logic [7:0] lo_q;

  always_comb begin
    pop = 1'b0;
    case (state)
      RD_IDLE:  pop = rd_req & ~flush & not_empty;
      RD_FIRST: pop = ~flush & ~mode_q & not_empty;
      default:  pop = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RD_IDLE;
      mode_q  <= 1'b0;
      lo_q    <= '0;
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack <= 1'b0;
      if (flush) begin
        // an outstanding or new request is answered with zero
        if (state != RD_IDLE || rd_req) begin
          rd_ack  <= 1'b1;
          rd_data <= '0;
        end
        state <= RD_IDLE;
      end else begin
        case (state)
          RD_IDLE: begin
            if (rd_req) begin
              if (!not_empty) begin
                rd_ack  <= 1'b1;
                rd_data <= '0;
              end else begin
                mode_q <= stat_mode;
                state  <= RD_FIRST;
              end
            end
          end
          RD_FIRST: begin
            if (mode_q) begin
              rd_data <= {4'h0, ram_q};
              rd_ack  <= 1'b1;
              state   <= RD_IDLE;
            end else if (not_empty) begin
              lo_q  <= ram_q.data;
              state <= RD_SECOND;
            end else begin
              rd_data <= {8'h00, ram_q.data};
              rd_ack  <= 1'b1;
              state   <= RD_IDLE;
            end
          end
          default: begin
            rd_data <= {ram_q.data, lo_q};
            rd_ack  <= 1'b1;
            state   <= RD_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rxq_status.sv
module rxq_status (
  input  logic        clk,
  input  logic        rst,
  input  logic        cts_in,
  input  logic        dsr_in,
  input  logic        cd_in,
  input  logic        tx_fifo_empty,
  input  logic        tx_shift_empty,
  input  logic        not_empty,
  input  logic        stat_mode,
  input  logic        accept,
  input  logic [7:0]  chr,
  input  logic        chr_brk,
  input  logic        chr_frm,
  input  logic        chr_par,
  input  logic        ovf_evt,
  input  logic        cmp1_en,
  input  logic [7:0]  cmp1,
  input  logic        cmp2_en,
  input  logic [7:0]  cmp2,
  input  logic        stat_rd,
  output logic [15:0] stat_word
);
  localparam int NSTICKY = 6;

  logic [5:0]         live_q;
  logic               mode_q;
  logic [NSTICKY-1:0] sticky_q;
  logic [NSTICKY-1:0] set_v;

  // order: overflow, cmp2, cmp1, break, framing, parity
  assign set_v = {ovf_evt,
                  accept & cmp2_en & (chr == cmp2),
                  accept & cmp1_en & (chr == cmp1),
                  accept & chr_brk,
                  accept & chr_frm,
                  accept & chr_par};

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      mode_q <= 1'b0;
    end else begin
      live_q <= {cts_in, dsr_in, cd_in, tx_fifo_empty, tx_shift_empty, not_empty};
      mode_q <= stat_mode;
    end
  end

  for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst)            sticky_q[i] <= 1'b0;
      else if (set_v[i])  sticky_q[i] <= 1'b1;
      else if (stat_rd)   sticky_q[i] <= 1'b0;
    end
  end

  assign stat_word = {mode_q, 1'b0, sticky_q, 2'b00, live_q};
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import rxq_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_char,
  input  logic          rx_brk,
  input  logic          rx_frm,
  input  logic          rx_ovr,
  input  logic          rx_par,
  input  logic          cts_in,
  input  logic          dsr_in,
  input  logic          cd_in,
  input  logic          tx_fifo_empty,
  input  logic          tx_shift_empty,
  input  logic          cfg_stat_mode,
  input  logic [1:0]    cfg_trig,
  input  logic          cfg_rx_int_en,
  input  logic          cfg_cmp1_en,
  input  logic [7:0]    cfg_cmp1,
  input  logic          cfg_cmp2_en,
  input  logic [7:0]    cfg_cmp2,
  input  logic          flush,
  input  logic          rd_req,
  output logic          rd_ack,
  output logic [15:0]   rd_data,
  input  logic          stat_rd,
  output logic [15:0]   stat_word,
  output logic [AW-1:0] rx_count,
  output logic          trig_flag,
  output logic          rx_irq
);
  rx_entry_t          wr_entry;
  rx_entry_t          rd_entry;
  logic [ENTRY_W-1:0] ram_q;
  logic [AW-1:0]      wptr;
  logic [AW-1:0]      rptr;
  logic               accept;
  logic               ovf_evt;
  logic               pop;
  logic               not_empty;

  assign wr_entry  = '{brk: rx_brk, frm: rx_frm, ovr: rx_ovr, par: rx_par, data: rx_char};
  assign rd_entry  = rx_entry_t'(ram_q);
  assign not_empty = (rx_count != '0);

  rxq_ram #(.AW(AW), .DW(ENTRY_W)) u_ram (
    .clk   (clk),
    .we    (accept),
    .waddr (wptr),
    .wdata (wr_entry),
    .raddr (rptr),
    .q     (ram_q)
  );

  rxq_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .wr_req    (rx_valid),
    .pop       (pop),
    .cfg_trig  (cfg_trig),
    .int_en    (cfg_rx_int_en),
    .accept    (accept),
    .ovf_evt   (ovf_evt),
    .wptr      (wptr),
    .rptr      (rptr),
    .count     (rx_count),
    .trig_flag (trig_flag),
    .irq       (rx_irq)
  );

  rxq_rdport u_rdport (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .rd_req    (rd_req),
    .stat_mode (cfg_stat_mode),
    .not_empty (not_empty),
    .ram_q     (rd_entry),
    .pop       (pop),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data)
  );

  rxq_status u_status (
    .clk            (clk),
    .rst            (rst),
    .cts_in         (cts_in),
    .dsr_in         (dsr_in),
    .cd_in          (cd_in),
    .tx_fifo_empty  (tx_fifo_empty),
    .tx_shift_empty (tx_shift_empty),
    .not_empty      (not_empty),
    .stat_mode      (cfg_stat_mode),
    .accept         (accept),
    .chr            (rx_char),
    .chr_brk        (rx_brk),
    .chr_frm        (rx_frm),
    .chr_par        (rx_par),
    .ovf_evt        (ovf_evt),
    .cmp1_en        (cfg_cmp1_en),
    .cmp1           (cfg_cmp1),
    .cmp2_en        (cfg_cmp2_en),
    .cmp2           (cfg_cmp2),
    .stat_rd        (stat_rd),
    .stat_word      (stat_word)
  );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic          flush,
  input logic          stat_rd,
  input logic [1:0]    cfg_trig,
  input logic          cfg_rx_int_en,
  input logic [AW-1:0] rx_count,
  input logic [5:0]    sticky,
  input logic          rda,
  input logic          trig_flag,
  input logic          rx_irq
);
  localparam logic [AW-1:0] CAP = {AW{1'b1}};

  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rx_count == CAP && rx_valid && !flush) |=> sticky[5]); // R1

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
    (rx_count == CAP && rx_valid && !flush) |=> (rx_count >= CAP - 1'b1)); // R1

  AST_RDA_SET: assert property (@(posedge clk) disable iff (rst)
    (rx_count != '0) |=> rda); // R4

  AST_RDA_CLR: assert property (@(posedge clk) disable iff (rst)
    (rx_count == '0) |=> !rda); // R4

  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !rx_valid) |=> (sticky == 6'b0)); // R6

  AST_TRIG_OFF: assert property (@(posedge clk) disable iff (rst)
    (cfg_trig == 2'b00) |=> !trig_flag); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !cfg_rx_int_en |=> !rx_irq); // R9

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (rx_count == '0)); // R10
endmodule

bind serial_rx_queue rxq_checker #(.AW(AW)) u_rxq_checker (
  .clk           (clk),
  .rst           (rst),
  .rx_valid      (rx_valid),
  .flush         (flush),
  .stat_rd       (stat_rd),
  .cfg_trig      (cfg_trig),
  .cfg_rx_int_en (cfg_rx_int_en),
  .rx_count      (rx_count),
  .sticky        (stat_word[13:8]),
  .rda           (stat_word[0]),
  .trig_flag     (trig_flag),
  .rx_irq        (rx_irq)
);

// File: tb/test_serial_rx_queue.sv
module test_serial_rx_queue;
  localparam int AW  = 10;
  localparam int CAP = 1023;
  localparam int NV  = 7;

  // {stat_mode, c0, f0, c1, f1, expected}; flags are {brk,frm,ovr,par}
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h41, 4'h0, 8'h00, 4'h0, 16'h0041},
    {1'b1, 8'h7E, 4'h8, 8'h00, 4'h0, 16'h087E},
    {1'b1, 8'h00, 4'h5, 8'h00, 4'h0, 16'h0500},
    {1'b1, 8'hFF, 4'h2, 8'h00, 4'h0, 16'h02FF},
    {1'b0, 8'h12, 4'h0, 8'h34, 4'h0, 16'h3412},
    {1'b0, 8'hA5, 4'hF, 8'h5A, 4'h8, 16'h5AA5},
    {1'b0, 8'h00, 4'h0, 8'hFF, 4'h0, 16'hFF00}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_char = '0;
  logic          rx_brk = 1'b0, rx_frm = 1'b0, rx_ovr = 1'b0, rx_par = 1'b0;
  logic          cts_in = 1'b0, dsr_in = 1'b0, cd_in = 1'b0;
  logic          tx_fifo_empty = 1'b0, tx_shift_empty = 1'b0;
  logic          cfg_stat_mode = 1'b0;
  logic [1:0]    cfg_trig = 2'b00;
  logic          cfg_rx_int_en = 1'b0;
  logic          cfg_cmp1_en = 1'b0, cfg_cmp2_en = 1'b0;
  logic [7:0]    cfg_cmp1 = '0, cfg_cmp2 = '0;
  logic          flush = 1'b0;
  logic          rd_req = 1'b0;
  logic          rd_ack;
  logic [15:0]   rd_data;
  logic          stat_rd = 1'b0;
  logic [15:0]   stat_word;
  logic [AW-1:0] rx_count;
  logic          trig_flag;
  logic          rx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  serial_rx_queue #(.AW(AW)) i_serial_rx_queue (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_ovr(rx_ovr), .rx_par(rx_par),
    .cts_in(cts_in), .dsr_in(dsr_in), .cd_in(cd_in),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
    .cfg_stat_mode(cfg_stat_mode), .cfg_trig(cfg_trig),
    .cfg_rx_int_en(cfg_rx_int_en), .cfg_cmp1_en(cfg_cmp1_en),
    .cfg_cmp1(cfg_cmp1), .cfg_cmp2_en(cfg_cmp2_en), .cfg_cmp2(cfg_cmp2),
    .flush(flush), .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .stat_rd(stat_rd), .stat_word(stat_word), .rx_count(rx_count),
    .trig_flag(trig_flag), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] c, input logic [3:0] f);
    rx_valid = 1'b1;
    rx_char  = c;
    {rx_brk, rx_frm, rx_ovr, rx_par} = f;
    @(negedge clk);
    rx_valid = 1'b0;
    {rx_brk, rx_frm, rx_ovr, rx_par} = 4'h0;
  endtask

  task automatic hread(output logic [15:0] d);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    for (int k = 0; k < 8 && !rd_ack; k++) @(negedge clk);
    d = rd_ack ? rd_data : 16'hDEAD;
    @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int bad;
    settle(3);
    rst = 1'b0;
    settle(1);

    // R11 reset state
    chk("R11 count", 32'(rx_count), 0);
    chk("R11 status", 32'(stat_word), 0);
    chk("R11 trig/irq/ack", {trig_flag, rx_irq, rd_ack}, 0);

    // R4 live flags
    cts_in = 1'b1; cd_in = 1'b1; tx_fifo_empty = 1'b1;
    settle(2);
    chk("R4 live low byte", 32'(stat_word[7:0]), 32'h2C);
    push(8'h11, 4'h0);
    settle(1);
    chk("R4 data available bit", 32'(stat_word[7:0]), 32'h2D);

    // R3 single-byte and empty reads
    hread(d);
    chk("R3 single byte read", 32'(d), 32'h0011);
    hread(d);
    chk("R3 empty read", 32'(d), 32'h0000);
    chk("R3 count after empty read", 32'(rx_count), 0);
    cts_in = 1'b0; cd_in = 1'b0; tx_fifo_empty = 1'b0;
    dsr_in = 1'b1; tx_shift_empty = 1'b1;
    settle(2);
    chk("R4 live low byte second pattern", 32'(stat_word[7:0]), 32'h12);

    // R2 / R3 vector table
    for (int v = 0; v < NV; v++) begin
      cfg_stat_mode = VEC[v][40];
      push(VEC[v][39:32], VEC[v][31:28]);
      if (!VEC[v][40]) push(VEC[v][27:20], VEC[v][19:16]);
      hread(d);
      chk(VEC[v][40] ? "R2 status-mode read" : "R3 two-byte read", 32'(d), 32'(VEC[v][15:0]));
    end

    // R5 sticky flags accumulated by the table
    cfg_stat_mode = 1'b1;
    settle(2);
    chk("R5 high byte", 32'(stat_word[15:8]), 32'h87);

    // R6 clear on read, and set wins over clear
    stat_rd = 1'b1;
    settle(1);
    stat_rd = 1'b0;
    chk("R6 sticky cleared", 32'(stat_word[13:8]), 0);
    stat_rd = 1'b1;
    push(8'h22, 4'h8);
    stat_rd = 1'b0;
    chk("R6 same-cycle break kept", 32'(stat_word[13:8]), 32'h04);
    hread(d);
    chk("R2 break char read", 32'(d), 32'h0822);
    stat_rd = 1'b1; settle(1); stat_rd = 1'b0;

    // R7 compare matches
    cfg_cmp1_en = 1'b1; cfg_cmp1 = 8'h55; cfg_cmp2 = 8'h66;
    push(8'h55, 4'h0);
    push(8'h66, 4'h0);
    chk("R7 cmp1 only", 32'(stat_word[12:11]), 32'h1);
    cfg_cmp2_en = 1'b1;
    push(8'h66, 4'h0);
    chk("R7 cmp1 and cmp2", 32'(stat_word[12:11]), 32'h3);
    flush = 1'b1; settle(1); flush = 1'b0;
    chk("R10 flush count", 32'(rx_count), 0);
    cfg_cmp1_en = 1'b0; cfg_cmp2_en = 1'b0;
    stat_rd = 1'b1; settle(1); stat_rd = 1'b0;

    // R8 / R9 trigger and interrupt
    cfg_trig = 2'b01;
    settle(2);
    chk("R8 level one empty", 32'(trig_flag), 0);
    push(8'h01, 4'h0);
    settle(1);
    chk("R8 level one reached", 32'(trig_flag), 1);
    chk("R9 irq disabled", 32'(rx_irq), 0);
    cfg_rx_int_en = 1'b1;
    settle(2);
    chk("R9 irq enabled", 32'(rx_irq), 1);
    cfg_rx_int_en = 1'b0;
    settle(2);
    chk("R9 trig without irq", {trig_flag, rx_irq}, 32'h2);

    flush = 1'b1; settle(1); flush = 1'b0;
    cfg_trig = 2'b10;
    for (int i = 0; i < 511; i++) push(8'(i), 4'h0);
    settle(2);
    chk("R8 half level at 511", 32'(trig_flag), 0);
    push(8'(511), 4'h0);
    settle(1);
    chk("R8 half level at 512", 32'(trig_flag), 1);
    cfg_trig = 2'b11;
    settle(2);
    chk("R8 seven-eighths at 512", 32'(trig_flag), 0);
    for (int i = 512; i < 895; i++) push(8'(i), 4'h0);
    settle(2);
    chk("R8 seven-eighths at 895", 32'(trig_flag), 0);
    push(8'(895), 4'h0);
    settle(1);
    chk("R8 seven-eighths at 896", 32'(trig_flag), 1);
    for (int i = 896; i < CAP; i++) push(8'(i), 4'h0);
    chk("R1 full count", 32'(rx_count), CAP);
    cfg_trig = 2'b00;
    settle(2);
    chk("R8 code none when full", 32'(trig_flag), 0);

    // R1 overflow
    push(8'hEE, 4'h8);
    chk("R1 count after overflow", 32'(rx_count), CAP);
    chk("R1 overflow set, break not recorded", {stat_word[13], stat_word[10]}, 32'h2);
    cfg_stat_mode = 1'b1;
    bad = 0;
    for (int i = 0; i < CAP; i++) begin
      hread(d);
      if (d !== {8'h00, 8'(i)}) bad++;
    end
    chk("R1 drained contents mismatches", bad, 0);
    chk("R1 count after drain", 32'(rx_count), 0);

    // R10 flush with simultaneous character
    push(8'h31, 4'h0);
    push(8'h32, 4'h0);
    push(8'h33, 4'h0);
    flush = 1'b1;
    push(8'h99, 4'h0);
    flush = 1'b0;
    chk("R10 count after flush", 32'(rx_count), 0);
    chk("R10 sticky overflow kept", 32'(stat_word[13]), 1);
    hread(d);
    chk("R10 flushed char discarded", 32'(d), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule